// File: doc/BRIEF.md
# Pipelined Control Signal Carrier

This block carries the decoded control word of one instruction down a five-stage integer pipeline. It has three register stages: decode-to-execute, execute-to-memory and memory-to-writeback. Control bits are sorted by the stage that uses them. Each stage register keeps only the groups that later stages still need. The execute group is used in the execute stage and then discarded. The memory group travels one stage further. The writeback group reaches the last stage.

In the execute stage, the block also picks the destination register number. It chooses between the two candidate fields of the instruction word and passes the chosen number down to writeback.

Two requests come from the hazard logic:
- A bubble request inserts an empty slot into the execute stage while the older instructions keep moving.
- A flush request squashes the two youngest instructions that are entering the execute and memory stages.

Top module: `ctrl_pipe_carrier`

## Requirements
- R1: A synchronous active-high reset clears every control bit and every valid flag in all three stage registers to 0 at the next clock edge.
- R2: Without bubble or flush, the execute-stage outputs (`ex_alu_op`, `ex_b_src`) show the decoded execute bits one clock after they are presented, with `ex_valid` = 1.
- R3: `ex_dst` equals `id_rd_field` (instruction bits 15:11) when the captured `id_dst_sel` is 1, and `id_rt_field` (instruction bits 20:16) when it is 0.
- R4: One clock after an instruction occupies execute, the memory-stage outputs show its memory bits (branch, read, write), its valid flag and the destination number chosen in execute.
- R5: One clock after an instruction occupies memory, the writeback outputs show its writeback bits (`wb_mem_to_reg`, `wb_reg_wr`) and its destination number.
- R6: When `bubble` is 1 at a clock edge, the execute stage is loaded with all control bits 0 and `ex_valid` = 0. That empty slot then reaches memory and writeback with all control bits 0 and its valid flag 0.
- R7: While a bubble is inserted, the memory and writeback stages advance normally, so the instruction that was in execute moves on to memory.
- R8: When `flush` is 1 at a clock edge, both the execute and the memory stages are loaded with all control bits 0 and their valid flags 0, while the writeback stage still takes the instruction that was in memory.
- R9: When `bubble` and `flush` are both 1 at the same edge, the result equals that of a flush alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bubble | input | 1 | Insert an empty slot into execute |
| flush | input | 1 | Squash the slots entering execute and memory |
| id_dst_sel | input | 1 | 1 selects the rd field, 0 the rt field |
| id_alu_op | input | 2 | ALU operation class |
| id_b_src | input | 1 | ALU second operand source select |
| id_branch | input | 1 | Branch in memory stage |
| id_mem_rd | input | 1 | Load access |
| id_mem_wr | input | 1 | Store access |
| id_mem_to_reg | input | 1 | Writeback takes memory data |
| id_reg_wr | input | 1 | Register file write enable |
| id_rt_field | input | 5 | Instruction bits 20:16 |
| id_rd_field | input | 5 | Instruction bits 15:11 |
| ex_valid | output | 1 | Execute slot holds a real instruction |
| ex_alu_op | output | 2 | Execute-stage ALU operation class |
| ex_b_src | output | 1 | Execute-stage operand source |
| ex_dst | output | 5 | Destination chosen in execute |
| mem_valid | output | 1 | Memory slot holds a real instruction |
| mem_branch | output | 1 | Memory-stage branch flag |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| mem_dst | output | 5 | Memory-stage destination |
| wb_valid | output | 1 | Writeback slot holds a real instruction |
| wb_mem_to_reg | output | 1 | Writeback data source |
| wb_reg_wr | output | 1 | Register write enable |
| wb_dst | output | 5 | Writeback destination |

## Verification
A bubble and a flush can both be requested at the same clock edge. Both claim the execute-stage load, and only the flush also squashes the memory stage.

The bench provokes this case after two instructions have entered the pipe. It then checks the same two things as for a flush alone:
- The execute and memory slots come out empty.
- The oldest instruction still arrives at writeback with its own register write bits and destination.

A separate sequence asserts a bubble alone. It checks that the memory slot keeps advancing, and it follows the empty slot until it has left writeback.

// File: rtl/cpc_pkg.sv
package cpc_pkg;
  parameter int CPC_ALU_OP_W = 2;
  parameter int CPC_REG_W    = 5;

  typedef struct packed {
    logic                    dst_sel;
    logic [CPC_ALU_OP_W-1:0] alu_op;
    logic                    b_src;
  } ex_ctl_t;

  typedef struct packed {
    logic branch;
    logic mem_rd;
    logic mem_wr;
  } mem_ctl_t;

  typedef struct packed {
    logic mem_to_reg;
    logic reg_wr;
  } wb_ctl_t;

  localparam int CPC_CTL_BITS = $bits(ex_ctl_t) + $bits(mem_ctl_t) + $bits(wb_ctl_t);
endpackage

// File: rtl/cpc_idex_stage.sv
module cpc_idex_stage
  import cpc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bubble,
  input  logic                 flush,
  input  ex_ctl_t              ex_in,
  input  mem_ctl_t             mem_in,
  input  wb_ctl_t              wb_in,
  input  logic [CPC_REG_W-1:0] rt_in,
  input  logic [CPC_REG_W-1:0] rd_in,
  output logic                 valid_q,
  output ex_ctl_t              ex_q,
  output mem_ctl_t             mem_q,
  output wb_ctl_t              wb_q,
  output logic [CPC_REG_W-1:0] rt_q,
  output logic [CPC_REG_W-1:0] rd_q
);
  logic kill;
  assign kill = bubble | flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      ex_q    <= '0;
      mem_q   <= '0;
      wb_q    <= '0;
      rt_q    <= '0;
      rd_q    <= '0;
    end else begin
      rt_q <= rt_in;
      rd_q <= rd_in;
      if (kill) begin
        valid_q <= 1'b0;
        ex_q    <= '0;
        mem_q   <= '0;
        wb_q    <= '0;
      end else begin
        valid_q <= 1'b1;
        ex_q    <= ex_in;
        mem_q   <= mem_in;
        wb_q    <= wb_in;
      end
    end
  end

  // R6
  idex_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bubble || flush) |-> (!valid_q && ex_q == '0 && mem_q == '0 && wb_q == '0));

  // R2
  idex_load_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!bubble && !flush && !rst) |-> (valid_q && ex_q == $past(ex_in) && wb_q == $past(wb_in)));
endmodule

// File: rtl/cpc_dst_pick.sv
module cpc_dst_pick
  import cpc_pkg::*;
(
  input  logic                 sel,
  input  logic [CPC_REG_W-1:0] rt,
  input  logic [CPC_REG_W-1:0] rd,
  output logic [CPC_REG_W-1:0] dst
);
  always_comb begin
    if (sel) dst = rd;
    else     dst = rt;
  end
endmodule

// File: rtl/cpc_exmem_stage.sv
module cpc_exmem_stage
  import cpc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  logic                 valid_in,
  input  mem_ctl_t             mem_in,
  input  wb_ctl_t              wb_in,
  input  logic [CPC_REG_W-1:0] dst_in,
  output logic                 valid_q,
  output mem_ctl_t             mem_q,
  output wb_ctl_t              wb_q,
  output logic [CPC_REG_W-1:0] dst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mem_q   <= '0;
      wb_q    <= '0;
      dst_q   <= '0;
    end else begin
      dst_q <= dst_in;
      if (flush) begin
        valid_q <= 1'b0;
        mem_q   <= '0;
        wb_q    <= '0;
      end else begin
        valid_q <= valid_in;
        mem_q   <= mem_in;
        wb_q    <= wb_in;
      end
    end
  end

  // R8
  exmem_flush_chk: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (!valid_q && mem_q == '0 && wb_q == '0));

  // R4
  exmem_carry_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!flush && !rst) |-> (valid_q == $past(valid_in) && mem_q == $past(mem_in)
                               && dst_q == $past(dst_in)));
endmodule

// File: rtl/cpc_memwb_stage.sv
module cpc_memwb_stage
  import cpc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  wb_ctl_t              wb_in,
  input  logic [CPC_REG_W-1:0] dst_in,
  output logic                 valid_q,
  output wb_ctl_t              wb_q,
  output logic [CPC_REG_W-1:0] dst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      wb_q    <= '0;
      dst_q   <= '0;
    end else begin
      valid_q <= valid_in;
      wb_q    <= wb_in;
      dst_q   <= dst_in;
    end
  end

  // R5
  memwb_carry_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (wb_q == $past(wb_in) && dst_q == $past(dst_in) && valid_q == $past(valid_in)));

  // R1
  memwb_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_q && wb_q == '0));
endmodule

// File: rtl/ctrl_pipe_carrier.sv
module ctrl_pipe_carrier
  import cpc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bubble,
  input  logic                    flush,
  input  logic                    id_dst_sel,
  input  logic [CPC_ALU_OP_W-1:0] id_alu_op,
  input  logic                    id_b_src,
  input  logic                    id_branch,
  input  logic                    id_mem_rd,
  input  logic                    id_mem_wr,
  input  logic                    id_mem_to_reg,
  input  logic                    id_reg_wr,
  input  logic [CPC_REG_W-1:0]    id_rt_field,
  input  logic [CPC_REG_W-1:0]    id_rd_field,
  output logic                    ex_valid,
  output logic [CPC_ALU_OP_W-1:0] ex_alu_op,
  output logic                    ex_b_src,
  output logic [CPC_REG_W-1:0]    ex_dst,
  output logic                    mem_valid,
  output logic                    mem_branch,
  output logic                    mem_rd_en,
  output logic                    mem_wr_en,
  output logic [CPC_REG_W-1:0]    mem_dst,
  output logic                    wb_valid,
  output logic                    wb_mem_to_reg,
  output logic                    wb_reg_wr,
  output logic [CPC_REG_W-1:0]    wb_dst
);
  ex_ctl_t  id_ex, x_ex;
  mem_ctl_t id_mem, x_mem, m_mem;
  wb_ctl_t  id_wb, x_wb, m_wb, w_wb;
  logic [CPC_REG_W-1:0] x_rt, x_rd, x_dst, m_dst, w_dst;
  logic x_valid, m_valid, w_valid;

  always_comb begin
    id_ex.dst_sel     = id_dst_sel;
    id_ex.alu_op      = id_alu_op;
    id_ex.b_src       = id_b_src;
    id_mem.branch     = id_branch;
    id_mem.mem_rd     = id_mem_rd;
    id_mem.mem_wr     = id_mem_wr;
    id_wb.mem_to_reg  = id_mem_to_reg;
    id_wb.reg_wr      = id_reg_wr;
  end

  cpc_idex_stage u_idex (
    .clk(clk), .rst(rst), .bubble(bubble), .flush(flush),
    .ex_in(id_ex), .mem_in(id_mem), .wb_in(id_wb),
    .rt_in(id_rt_field), .rd_in(id_rd_field),
    .valid_q(x_valid), .ex_q(x_ex), .mem_q(x_mem), .wb_q(x_wb),
    .rt_q(x_rt), .rd_q(x_rd)
  );

  cpc_dst_pick u_pick (
    .sel(x_ex.dst_sel), .rt(x_rt), .rd(x_rd), .dst(x_dst)
  );

  cpc_exmem_stage u_exmem (
    .clk(clk), .rst(rst), .flush(flush),
    .valid_in(x_valid), .mem_in(x_mem), .wb_in(x_wb), .dst_in(x_dst),
    .valid_q(m_valid), .mem_q(m_mem), .wb_q(m_wb), .dst_q(m_dst)
  );

  cpc_memwb_stage u_memwb (
    .clk(clk), .rst(rst),
    .valid_in(m_valid), .wb_in(m_wb), .dst_in(m_dst),
    .valid_q(w_valid), .wb_q(w_wb), .dst_q(w_dst)
  );

  assign ex_valid      = x_valid;
  assign ex_alu_op     = x_ex.alu_op;
  assign ex_b_src      = x_ex.b_src;
  assign ex_dst        = x_dst;
  assign mem_valid     = m_valid;
  assign mem_branch    = m_mem.branch;
  assign mem_rd_en     = m_mem.mem_rd;
  assign mem_wr_en     = m_mem.mem_wr;
  assign mem_dst       = m_dst;
  assign wb_valid      = w_valid;
  assign wb_mem_to_reg = w_wb.mem_to_reg;
  assign wb_reg_wr     = w_wb.reg_wr;
  assign wb_dst        = w_dst;
endmodule

// File: tb/ctrl_pipe_carrier_tb.sv
module ctrl_pipe_carrier_tb;
  logic clk = 1'b0;
  logic rst, bubble, flush;
  logic dsel, bsrc, br, mrd, mwr, m2r, rwr;
  logic [1:0] aop;
  logic [4:0] rt, rd;
  logic ex_valid, ex_b_src, mem_valid, mem_branch, mem_rd_en, mem_wr_en;
  logic wb_valid, wb_mem_to_reg, wb_reg_wr;
  logic [1:0] ex_alu_op;
  logic [4:0] ex_dst, mem_dst, wb_dst;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ctrl_pipe_carrier u_dut (
    .clk(clk), .rst(rst), .bubble(bubble), .flush(flush),
    .id_dst_sel(dsel), .id_alu_op(aop), .id_b_src(bsrc), .id_branch(br),
    .id_mem_rd(mrd), .id_mem_wr(mwr), .id_mem_to_reg(m2r), .id_reg_wr(rwr),
    .id_rt_field(rt), .id_rd_field(rd),
    .ex_valid(ex_valid), .ex_alu_op(ex_alu_op), .ex_b_src(ex_b_src), .ex_dst(ex_dst),
    .mem_valid(mem_valid), .mem_branch(mem_branch), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_dst(mem_dst),
    .wb_valid(wb_valid), .wb_mem_to_reg(wb_mem_to_reg), .wb_reg_wr(wb_reg_wr), .wb_dst(wb_dst)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] op, input logic bs, input logic ds, input logic b,
                     input logic r, input logic w, input logic mr, input logic rw,
                     input logic [4:0] f_rt, input logic [4:0] f_rd);
    aop = op; bsrc = bs; dsel = ds; br = b; mrd = r; mwr = w; m2r = mr; rwr = rw;
    rt = f_rt; rd = f_rd;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; bubble = 1'b0; flush = 1'b0;
    step(); step();
    rst = 1'b0;
  endtask

  // Instruction A: load-like, dst rd=9; B: store-like, dst rt=7; C: branch, dst rd=3
  task automatic put_a(); put(2'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd5, 5'd9); endtask
  task automatic put_b(); put(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd7, 5'd12); endtask
  task automatic put_c(); put(2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd4, 5'd3); endtask

  task automatic t_reset();
    put_a();
    rst = 1'b1; bubble = 1'b0; flush = 1'b0;
    step();
    chk("R1 ex_valid", ex_valid, 0);
    chk("R1 ex_alu_op", ex_alu_op, 0);
    chk("R1 mem_valid", mem_valid, 0);
    chk("R1 mem_rd_en", mem_rd_en, 0);
    chk("R1 wb_valid", wb_valid, 0);
    chk("R1 wb_reg_wr", wb_reg_wr, 0);
    rst = 1'b0;
    step(); step(); step();
    // pipe full of A; reset again mid-stream
    rst = 1'b1;
    step();
    chk("R1 mid ex_b_src", ex_b_src, 0);
    chk("R1 mid mem_rd_en", mem_rd_en, 0);
    chk("R1 mid wb_reg_wr", wb_reg_wr, 0);
    chk("R1 mid wb_mem_to_reg", wb_mem_to_reg, 0);
    rst = 1'b0;
  endtask

  task automatic t_flow();
    do_reset();
    put_a(); step();
    chk("R2 ex_valid", ex_valid, 1);
    chk("R2 ex_alu_op", ex_alu_op, 2);
    chk("R2 ex_b_src", ex_b_src, 1);
    chk("R3 ex_dst rd", ex_dst, 9);
    put_b(); step();
    chk("R3 ex_dst rt", ex_dst, 7);
    chk("R4 mem_valid", mem_valid, 1);
    chk("R4 mem_rd_en", mem_rd_en, 1);
    chk("R4 mem_wr_en", mem_wr_en, 0);
    chk("R4 mem_dst", mem_dst, 9);
    put_c(); step();
    chk("R3 ex_dst rd C", ex_dst, 3);
    chk("R4 mem_wr_en B", mem_wr_en, 1);
    chk("R4 mem_dst B", mem_dst, 7);
    chk("R5 wb_valid", wb_valid, 1);
    chk("R5 wb_reg_wr", wb_reg_wr, 1);
    chk("R5 wb_mem_to_reg", wb_mem_to_reg, 1);
    chk("R5 wb_dst", wb_dst, 9);
    step();
    chk("R4 mem_branch C", mem_branch, 1);
    chk("R5 wb_reg_wr B", wb_reg_wr, 0);
    chk("R5 wb_dst B", wb_dst, 7);
  endtask

  task automatic t_bubble();
    do_reset();
    put_a(); step();
    put_b(); bubble = 1'b1; step();
    bubble = 1'b0;
    chk("R6 ex_valid", ex_valid, 0);
    chk("R6 ex_alu_op", ex_alu_op, 0);
    chk("R6 ex_b_src", ex_b_src, 0);
    chk("R7 mem_valid", mem_valid, 1);
    chk("R7 mem_rd_en", mem_rd_en, 1);
    chk("R7 mem_dst", mem_dst, 9);
    put_c(); step();
    chk("R6 mem_valid", mem_valid, 0);
    chk("R6 mem_rd_en", mem_rd_en, 0);
    chk("R6 mem_wr_en", mem_wr_en, 0);
    chk("R7 wb_reg_wr", wb_reg_wr, 1);
    chk("R7 wb_dst", wb_dst, 9);
    chk("R2 ex after bubble", ex_alu_op, 1);
    step();
    chk("R6 wb_valid", wb_valid, 0);
    chk("R6 wb_reg_wr", wb_reg_wr, 0);
    chk("R6 wb_mem_to_reg", wb_mem_to_reg, 0);
  endtask

  task automatic t_flush(input bit with_bubble, input string tag);
    do_reset();
    put_a(); step();
    put_b(); step();
    put_c(); flush = 1'b1; bubble = with_bubble; step();
    flush = 1'b0; bubble = 1'b0;
    chk({tag, " ex_valid"}, ex_valid, 0);
    chk({tag, " ex_alu_op"}, ex_alu_op, 0);
    chk({tag, " mem_valid"}, mem_valid, 0);
    chk({tag, " mem_wr_en"}, mem_wr_en, 0);
    chk({tag, " wb_valid"}, wb_valid, 1);
    chk({tag, " wb_reg_wr"}, wb_reg_wr, 1);
    chk({tag, " wb_dst"}, wb_dst, 9);
    step();
    chk({tag, " wb squashed valid"}, wb_valid, 0);
    chk({tag, " wb squashed reg_wr"}, wb_reg_wr, 0);
  endtask

  initial begin
    rst = 1'b1; bubble = 1'b0; flush = 1'b0;
    put(2'd0, 0, 0, 0, 0, 0, 0, 0, 5'd0, 5'd0);
    step();
    t_reset();
    t_flow();
    t_bubble();
    t_flush(1'b0, "R8");
    t_flush(1'b1, "R9");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule